// File: doc/BRIEF.md
# Cell-Grid VGA Raster Generator

This block produces the timing for a 640x480 display refreshed 60 times per second, running from a 25 MHz pixel clock. On every clock it presents the coordinate of the pixel being scanned, both in pixels and in cells of an 80x60 grid, where each cell covers an 8x8 pixel square. A neighbouring grid store answers combinationally in the same cycle with a single on/off bit for that cell.

On the following rising edge the block turns that bit into a 12-bit colour. Live cells take a colour chosen by eight switch inputs. Dead cells are shown white. Pixels outside the visible window are black. The sync pulses and a start-of-frame strobe come out of the same register stage, so every output describes the pixel that was requested one clock earlier.

The raster is free-running and cannot stall. The coordinate request therefore has no back-pressure: the answering logic must return its bit within the same cycle.

Top module: `vga_cell_raster`

## Requirements
- R1: The pixel coordinate `req_x` counts 0..799 and wraps to 0. `req_y` counts 0..524 and advances by one when `req_x` wraps from 799. Both counters start at 0 after reset.
- R2: `req_active` is 1 exactly when `req_x` < 640 and `req_y` < 480.
- R3: `cell_col` equals `req_x` shifted right by 3, and `cell_row` equals `req_y` shifted right by 3.
- R4: One clock after a visible request answered with `cell_on`=1, the colour outputs are as follows. `vga_r` = {sw[7:5],0}, `vga_g` = {sw[4:2],0} and `vga_b` = {sw[1:0],00}, using the switch value present at that edge.
- R5: One clock after a visible request answered with `cell_on`=0, all three colour outputs are 4'hF.
- R6: One clock after a request outside the visible window, all colour outputs are 0, whatever `cell_on` and `sw` are.
- R7: One clock after a request, `hsync_n` is 0 exactly when that request's x was in 656..751. `vsync_n` is 0 exactly when its y was in 490..491. Both are 1 otherwise.
- R8: `frame_start` is 1 for one clock only: the clock after the request at (0,0).
- R9: While `rst_n` is low, the coordinates are 0, the colours are 0, both syncs are 1 and `frame_start` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sw | input | 8 | Live-cell colour switches (3 red, 3 green, 2 blue) |
| cell_on | input | 1 | On/off bit for the requested cell, same cycle |
| req_x | output | X_W (10) | Pixel column being requested |
| req_y | output | Y_W (10) | Pixel row being requested |
| cell_col | output | X_W-CELL_SHIFT (7) | Requested cell column |
| cell_row | output | Y_W-CELL_SHIFT (7) | Requested cell row |
| req_active | output | 1 | Requested pixel lies in the visible window |
| vga_r | output | 4 | Red, one clock after request |
| vga_g | output | 4 | Green, one clock after request |
| vga_b | output | 4 | Blue, one clock after request |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| frame_start | output | 1 | One-clock start-of-frame strobe |

## Verification
The bench builds the block with a scaled raster. A line is 16 visible pixels plus porches of 2 and 2 and a 3-clock sync, 23 clocks in all. A frame is 8 visible lines plus porches of 1 and 1 and a 2-line sync, 12 lines in all. The cell shift is 2. A whole frame is then only 276 clocks, so the bench can compare every pixel position over several complete frames against arithmetic expectations. This covers every wrap, porch edge, sync edge and the frame strobe. Each pass uses a different switch value and a different cell pattern, and a reset is applied in mid-frame.

// File: rtl/vga_raster_pkg.sv
package vga_raster_pkg;

  typedef struct packed {
    logic [3:0] r;
    logic [3:0] g;
    logic [3:0] b;
  } rgb12_t;

  localparam rgb12_t RGB_WHITE = '{r: 4'hF, g: 4'hF, b: 4'hF};
  localparam rgb12_t RGB_BLACK = '{r: 4'h0, g: 4'h0, b: 4'h0};

  // switch byte -> colour: 3 red, 3 green, 2 blue, each left-aligned in its channel
  function automatic rgb12_t switch_colour(input logic [7:0] sw);
    rgb12_t c;
    c.r = {sw[7:5], 1'b0};
    c.g = {sw[4:2], 1'b0};
    c.b = {sw[1:0], 2'b00};
    return c;
  endfunction

endpackage

// File: rtl/vga_axis_timer.sv
module vga_axis_timer #(
  parameter int VIS  = 640,
  parameter int FP   = 16,
  parameter int SYNC = 96,
  parameter int BP   = 48,
  parameter int W    = $clog2(VIS + FP + SYNC + BP)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] cnt,
  output logic         wrap,
  output logic         visible,
  output logic         sync_on
);
  localparam int TOTAL      = VIS + FP + SYNC + BP;
  localparam int SYNC_START = VIS + FP;
  localparam int SYNC_END   = VIS + FP + SYNC;

  logic at_last;
  assign at_last = (cnt == W'(TOTAL - 1));
  assign wrap    = step && at_last;
  assign visible = (cnt < W'(VIS));
  assign sync_on = (cnt >= W'(SYNC_START)) && (cnt < W'(SYNC_END));

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt <= '0;
    else if (wrap) cnt <= '0;
    else if (step) cnt <= cnt + 1'b1;
  end

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < W'(TOTAL)); // R1
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0)); // R1
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(cnt)); // R1

endmodule

// File: rtl/vga_pixel_stage.sv
module vga_pixel_stage
  import vga_raster_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       vis,
  input  logic       hsync_on,
  input  logic       vsync_on,
  input  logic       sof,
  input  logic       cell_on,
  input  logic [7:0] sw,
  output rgb12_t     rgb,
  output logic       hsync_n,
  output logic       vsync_n,
  output logic       frame_start
);
  rgb12_t rgb_next;

  always_comb begin
    if (!vis)         rgb_next = RGB_BLACK;
    else if (cell_on) rgb_next = switch_colour(sw);
    else              rgb_next = RGB_WHITE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rgb         <= RGB_BLACK;
      hsync_n     <= 1'b1;
      vsync_n     <= 1'b1;
      frame_start <= 1'b0;
    end else begin
      rgb         <= rgb_next;
      hsync_n     <= !hsync_on;
      vsync_n     <= !vsync_on;
      frame_start <= sof;
    end
  end

  AST_LIVE_COLOUR: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && cell_on) |=> (rgb == switch_colour($past(sw)))); // R4
  AST_DEAD_WHITE: assert property (@(posedge clk) disable iff (!rst_n)
    (vis && !cell_on) |=> (rgb == RGB_WHITE)); // R5
  AST_BLANK_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    !vis |=> (rgb == RGB_BLACK)); // R6
  AST_BLANK_IN_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (!hsync_n || !vsync_n) |-> (rgb == RGB_BLACK)); // R7

endmodule

// File: rtl/vga_cell_raster.sv
module vga_cell_raster
  import vga_raster_pkg::*;
#(
  parameter int H_VIS      = 640,
  parameter int H_FP       = 16,
  parameter int H_SYNC     = 96,
  parameter int H_BP       = 48,
  parameter int V_VIS      = 480,
  parameter int V_FP       = 10,
  parameter int V_SYNC     = 2,
  parameter int V_BP       = 33,
  parameter int CELL_SHIFT = 3,
  parameter int X_W        = $clog2(H_VIS + H_FP + H_SYNC + H_BP),
  parameter int Y_W        = $clog2(V_VIS + V_FP + V_SYNC + V_BP)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [7:0]            sw,
  input  logic                  cell_on,
  output logic [X_W-1:0]        req_x,
  output logic [Y_W-1:0]        req_y,
  output logic [X_W-CELL_SHIFT-1:0] cell_col,
  output logic [Y_W-CELL_SHIFT-1:0] cell_row,
  output logic                  req_active,
  output logic [3:0]            vga_r,
  output logic [3:0]            vga_g,
  output logic [3:0]            vga_b,
  output logic                  hsync_n,
  output logic                  vsync_n,
  output logic                  frame_start
);
  logic h_wrap, h_vis, h_sync_on;
  logic v_wrap, v_vis, v_sync_on;
  logic sof;
  rgb12_t rgb;

  vga_axis_timer #(
    .VIS(H_VIS), .FP(H_FP), .SYNC(H_SYNC), .BP(H_BP), .W(X_W)
  ) u_h_axis (
    .clk(clk), .rst_n(rst_n), .step(1'b1),
    .cnt(req_x), .wrap(h_wrap), .visible(h_vis), .sync_on(h_sync_on)
  );

  vga_axis_timer #(
    .VIS(V_VIS), .FP(V_FP), .SYNC(V_SYNC), .BP(V_BP), .W(Y_W)
  ) u_v_axis (
    .clk(clk), .rst_n(rst_n), .step(h_wrap),
    .cnt(req_y), .wrap(v_wrap), .visible(v_vis), .sync_on(v_sync_on)
  );

  // divide by the cell size: drop the low coordinate bits
  assign cell_col   = req_x[X_W-1:CELL_SHIFT];
  assign cell_row   = req_y[Y_W-1:CELL_SHIFT];
  assign req_active = h_vis && v_vis;
  assign sof        = (req_x == '0) && (req_y == '0);

  vga_pixel_stage u_stage (
    .clk(clk), .rst_n(rst_n),
    .vis(req_active), .hsync_on(h_sync_on), .vsync_on(v_sync_on),
    .sof(sof), .cell_on(cell_on), .sw(sw),
    .rgb(rgb), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .frame_start(frame_start)
  );

  assign vga_r = rgb.r;
  assign vga_g = rgb.g;
  assign vga_b = rgb.b;

  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start); // R8
  AST_FRAME_AT_ORIGIN: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (req_x == X_W'(1) && req_y == '0)); // R8
  AST_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (h_wrap && !v_wrap) |=> (req_y == $past(req_y) + 1'b1)); // R1

endmodule

// File: tb/vga_cell_raster_bench.sv
module vga_cell_raster_bench;
  localparam int HV = 16, HF = 2, HS = 3, HB = 2, HT = HV + HF + HS + HB;
  localparam int VV = 8,  VF = 1, VS = 2, VB = 1, VT = VV + VF + VS + VB;
  localparam int SH = 2;
  localparam int XW = $clog2(HT);
  localparam int YW = $clog2(VT);
  localparam int FRAME = HT * VT;

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] sw;
  logic cell_on;
  logic [XW-1:0] req_x;
  logic [YW-1:0] req_y;
  logic [XW-SH-1:0] cell_col;
  logic [YW-SH-1:0] cell_row;
  logic req_active;
  logic [3:0] vga_r, vga_g, vga_b;
  logic hsync_n, vsync_n, frame_start;

  int total = 0;
  int bad = 0;
  int seed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  vga_cell_raster #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .CELL_SHIFT(SH)
  ) u_vga_cell_raster (
    .clk(clk), .rst_n(rst_n), .sw(sw), .cell_on(cell_on),
    .req_x(req_x), .req_y(req_y), .cell_col(cell_col), .cell_row(cell_row),
    .req_active(req_active), .vga_r(vga_r), .vga_g(vga_g), .vga_b(vga_b),
    .hsync_n(hsync_n), .vsync_n(vsync_n), .frame_start(frame_start)
  );

  function automatic bit pattern(int col, int row, int s);
    return ((col * 3 + row + s) % 3) == 0;
  endfunction

  // grid model answers in the same cycle
  always_comb cell_on = pattern(int'(cell_col), int'(cell_row), seed);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic check_reset_outputs(string req);
    chk(req, int'({vga_r, vga_g, vga_b}), 0);
    chk(req, int'(hsync_n), 1);
    chk(req, int'(vsync_n), 1);
    chk(req, int'(frame_start), 0);
  endtask

  // k = rising edges since reset release
  task automatic check_step(int k);
    int p, x, y, q, qx, qy, er, eg, eb;
    bit vis;
    p = k % FRAME; x = p % HT; y = p / HT;
    chk("R1 req_x", int'(req_x), x);
    chk("R1 req_y", int'(req_y), y);
    chk("R2 req_active", int'(req_active), int'(x < HV && y < VV));
    chk("R3 cell_col", int'(cell_col), x >> SH);
    chk("R3 cell_row", int'(cell_row), y >> SH);
    if (k == 0) begin
      check_reset_outputs("R9 first cycle");
      return;
    end
    q = (k - 1) % FRAME; qx = q % HT; qy = q / HT;
    vis = (qx < HV) && (qy < VV);
    if (!vis) begin
      er = 0; eg = 0; eb = 0;
      chk("R6 blank colour", int'({vga_r, vga_g, vga_b}), 0);
    end else if (pattern(qx >> SH, qy >> SH, seed)) begin
      er = int'(sw[7:5]) * 2; eg = int'(sw[4:2]) * 2; eb = int'(sw[1:0]) * 4;
      chk("R4 live red", int'(vga_r), er);
      chk("R4 live green", int'(vga_g), eg);
      chk("R4 live blue", int'(vga_b), eb);
    end else begin
      chk("R5 dead colour", int'({vga_r, vga_g, vga_b}), 12'hFFF);
    end
    chk("R7 hsync_n", int'(hsync_n), int'(!(qx >= HV + HF && qx < HV + HF + HS)));
    chk("R7 vsync_n", int'(vsync_n), int'(!(qy >= VV + VF && qy < VV + VF + VS)));
    chk("R8 frame_start", int'(frame_start), int'(q == 0));
  endtask

  initial begin
    logic [7:0] sw_vals [4];
    int k;
    sw_vals[0] = 8'h00; sw_vals[1] = 8'hFF; sw_vals[2] = 8'hA5; sw_vals[3] = 8'h5A;
    rst_n = 1'b0;
    sw = 8'h00;
    repeat (3) @(negedge clk);
    chk("R9 reset x", int'(req_x), 0);
    chk("R9 reset y", int'(req_y), 0);
    check_reset_outputs("R9 in reset");
    rst_n = 1'b1;
    k = 0;
    check_step(k);
    for (int s = 0; s < 4; s++) begin
      sw = sw_vals[s];
      seed = s;
      for (int n = 0; n < 2 * FRAME; n++) begin
        @(negedge clk);
        k++;
        check_step(k);
      end
    end
    // reset in mid-frame
    for (int n = 0; n < 100; n++) begin
      @(negedge clk);
      k++;
      check_step(k);
    end
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 mid reset x", int'(req_x), 0);
    chk("R9 mid reset y", int'(req_y), 0);
    check_reset_outputs("R9 mid reset");
    rst_n = 1'b1;
    k = 0;
    check_step(k);
    for (int n = 0; n < FRAME + 10; n++) begin
      @(negedge clk);
      k++;
      check_step(k);
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(10 * 100000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule